// File: doc/BRIEF.md
# Power Control Request Handshake

This block connects a firmware processor that asks for power-control actions to a power-management controller that carries them out in software. The requester places a command (a kind code, a target domain and a unit mask) on its inputs and raises a request line. The block captures that command, shows it to the manager in a readable request register, and raises an interrupt toward the manager while no outcome has been given.

The manager reads the command and performs the action. It then writes an outcome into an acknowledge register: either success (complete) or failure (abort). The recorded outcome goes straight back to the requester on two status outputs. The requester ends the exchange by dropping its request. The block then clears the outcome, the interrupt and the captured command, and the next exchange can start.

The manager side is a simple word-addressed bus. It has a write strobe, an address and write data. Read data is combinational and follows the address.

Top module: `pwr_ctrl_hs`

## Requirements
- R1: After a synchronous reset, `mgr_irq_o`, `pwr_done_o` and `pwr_abort_o` are 0, and both the request register and the acknowledge register read 0.
- R2: The request register sits at word address 0. Its layout is: bits [3:0] kind code, bits [7:4] domain, bits [15:8] unit mask, bit [16] request pending, and all other bits 0. It shows the command one clock after the request line is first seen high.
- R3: The command is captured on the clock where the request line first rises. Changes on the command inputs while the request stays high do not alter the request register.
- R4: `mgr_irq_o` is high from the clock after the request rises until an outcome is recorded. It is low whenever no request is pending.
- R5: The acknowledge register sits at word address 1. Writing it with bit 0 set records "complete" and writing it with bit 1 set records "abort". The recorded outcome appears on `pwr_done_o` / `pwr_abort_o`, and reads back in the same bit positions, from the clock after the write.
- R6: A single write that sets both bit 0 and bit 1 records abort only.
- R7: Once an outcome is recorded, further acknowledge writes are ignored until the request is withdrawn.
- R8: Acknowledge writes while no request is pending have no effect.
- R9: One clock after the request line is seen low, the outcome bits, the interrupt and the whole request register are cleared to 0.
- R10: Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_req_i | input | 1 | Request line from the requester |
| pwr_kind_i | input | 4 | Command kind code |
| pwr_domain_i | input | 4 | Target power domain |
| pwr_mask_i | input | 8 | Unit mask |
| pwr_done_o | output | 1 | Outcome: completed |
| pwr_abort_o | output | 1 | Outcome: aborted |
| mgr_irq_o | output | 1 | Interrupt to the manager |
| mgr_wen_i | input | 1 | Register write strobe |
| mgr_addr_i | input | 2 | Register word address |
| mgr_wdata_i | input | 32 | Register write data |
| mgr_rdata_o | output | 32 | Register read data |

## Verification
The handshake is run with several command values and with different outcome writes: complete only, abort only, both bits together, and a second write after an outcome is already recorded. These distinguish set-only bits, abort priority and a sticky first result. Acknowledge writes made while idle, and writes to an unused address, show whether writes are gated correctly. Changing the command inputs in the middle of a request separates edge capture from a design that simply passes the inputs through. Reading back after withdrawal checks that the outcome, the interrupt and the captured fields are all cleared together.

// File: rtl/pwr_hs_pkg.sv
package pwr_hs_pkg;

    localparam int TYPE_W = 4;
    localparam int DOM_W  = 4;
    localparam int MASK_W = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam int CMD_W   = TYPE_W + DOM_W + MASK_W;
    localparam int PEND_BIT = CMD_W;

    localparam logic [ADDR_W-1:0] OFS_REQ = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_ACK = ADDR_W'(1);

    localparam int ACK_DONE_BIT  = 0;
    localparam int ACK_ABORT_BIT = 1;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [DOM_W-1:0]  domain;
        logic [TYPE_W-1:0] kind;
    } pwr_cmd_t;

    typedef enum logic [1:0] {
        RES_NONE  = 2'b00,
        RES_DONE  = 2'b01,
        RES_ABORT = 2'b10
    } pwr_res_t;

    // abort wins over complete when both bits are written
    function automatic pwr_res_t decode_ack(input logic [DATA_W-1:0] wd);
        pwr_res_t r;
        if (wd[ACK_ABORT_BIT])
            r = RES_ABORT;
        else if (wd[ACK_DONE_BIT])
            r = RES_DONE;
        else
            r = RES_NONE;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_req(input pwr_cmd_t c, input logic pend);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CMD_W-1:0] = c;
        r[PEND_BIT]  = pend;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ack(input pwr_res_t s);
        logic [DATA_W-1:0] r;
        r = '0;
        r[ACK_DONE_BIT]  = (s == RES_DONE);
        r[ACK_ABORT_BIT] = (s == RES_ABORT);
        return r;
    endfunction

endpackage

// File: rtl/pwr_cmd_capture.sv
module pwr_cmd_capture
    import pwr_hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  pwr_cmd_t cmd_i,
    output logic     pend_o,
    output pwr_cmd_t cmd_o
);

    logic     pend_q;
    pwr_cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cmd_q  <= '0;
        end else begin
            pend_q <= req_i;
            if (req_i && !pend_q)
                cmd_q <= cmd_i;
            else if (!req_i)
                cmd_q <= '0;
        end
    end

    assign pend_o = pend_q;
    assign cmd_o  = cmd_q;

    // R3
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && $past(pend_q)) |-> $stable(cmd_q));

endmodule

// File: rtl/pwr_result_reg.sv
module pwr_result_reg
    import pwr_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              pend_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output pwr_res_t          res_o
);

    pwr_res_t res_q;
    pwr_res_t res_new;

    assign res_new = decode_ack(wdata_i);

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= RES_NONE;
        else if (!req_i)
            res_q <= RES_NONE;
        else if (wr_i && pend_i && res_q == RES_NONE)
            res_q <= res_new;
    end

    assign res_o = res_q;

    // R8
    idle_no_result_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_i |-> (res_q == RES_NONE));

    // R7
    result_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_i && $past(res_q) != RES_NONE) |-> $stable(res_q));

endmodule

// File: rtl/pwr_reg_read.sv
module pwr_reg_read
    import pwr_hs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  pwr_cmd_t          cmd_i,
    input  logic              pend_i,
    input  pwr_res_t          res_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        case (addr_i)
            OFS_REQ: rdata_o = pack_req(cmd_i, pend_i);
            OFS_ACK: rdata_o = pack_ack(res_i);
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pwr_ctrl_hs.sv
module pwr_ctrl_hs
    import pwr_hs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_req_i,
    input  logic [TYPE_W-1:0] pwr_kind_i,
    input  logic [DOM_W-1:0]  pwr_domain_i,
    input  logic [MASK_W-1:0] pwr_mask_i,
    output logic              pwr_done_o,
    output logic              pwr_abort_o,
    output logic              mgr_irq_o,
    input  logic              mgr_wen_i,
    input  logic [ADDR_W-1:0] mgr_addr_i,
    input  logic [DATA_W-1:0] mgr_wdata_i,
    output logic [DATA_W-1:0] mgr_rdata_o
);

    pwr_cmd_t cmd_in;
    pwr_cmd_t cmd_held;
    logic     pend;
    pwr_res_t res;
    logic     ack_wr;

    assign cmd_in.kind   = pwr_kind_i;
    assign cmd_in.domain = pwr_domain_i;
    assign cmd_in.mask   = pwr_mask_i;
    assign ack_wr        = mgr_wen_i && (mgr_addr_i == OFS_ACK);

    pwr_cmd_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .req_i  (pwr_req_i),
        .cmd_i  (cmd_in),
        .pend_o (pend),
        .cmd_o  (cmd_held)
    );

    pwr_result_reg u_res (
        .clk     (clk),
        .rst     (rst),
        .req_i   (pwr_req_i),
        .pend_i  (pend),
        .wr_i    (ack_wr),
        .wdata_i (mgr_wdata_i),
        .res_o   (res)
    );

    pwr_reg_read u_rd (
        .addr_i  (mgr_addr_i),
        .cmd_i   (cmd_held),
        .pend_i  (pend),
        .res_i   (res),
        .rdata_o (mgr_rdata_o)
    );

    assign pwr_done_o  = (res == RES_DONE);
    assign pwr_abort_o = (res == RES_ABORT);
    assign mgr_irq_o   = pend && (res == RES_NONE);

    // R4
    irq_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> mgr_irq_o);

    // R9
    withdraw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> (!pwr_done_o && !pwr_abort_o && !mgr_irq_o));

endmodule

// File: tb/sim_pwr_ctrl_hs.sv
module sim_pwr_ctrl_hs;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [3:0]  kind;
    logic [3:0]  dom;
    logic [7:0]  mask;
    logic        done;
    logic        abrt;
    logic        irq;
    logic        wen;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pwr_ctrl_hs u0 (
        .clk          (clk),
        .rst          (rst),
        .pwr_req_i    (req),
        .pwr_kind_i   (kind),
        .pwr_domain_i (dom),
        .pwr_mask_i   (mask),
        .pwr_done_o   (done),
        .pwr_abort_o  (abrt),
        .mgr_irq_o    (irq),
        .mgr_wen_i    (wen),
        .mgr_addr_i   (addr),
        .mgr_wdata_i  (wdata),
        .mgr_rdata_o  (rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wen = 1'b1; addr = a; wdata = d;
        step();
        wen = 1'b0; wdata = '0;
    endtask

    function automatic logic [31:0] req_word(input logic [3:0] k, input logic [3:0] d,
                                             input logic [7:0] m, input logic p);
        return {15'b0, p, m, d, k};
    endfunction

    task automatic raise(input logic [3:0] k, input logic [3:0] d, input logic [7:0] m);
        req = 1'b1; kind = k; dom = d; mask = m;
        step();
    endtask

    task automatic withdraw(input string tag);
        logic [31:0] v;
        req = 1'b0;
        step();
        chk({tag, " R9 done"}, {31'b0, done}, 32'd0);
        chk({tag, " R9 abort"}, {31'b0, abrt}, 32'd0);
        chk({tag, " R9 irq"}, {31'b0, irq}, 32'd0);
        rd(2'd0, v); chk({tag, " R9 reqreg"}, v, 32'd0);
        rd(2'd1, v); chk({tag, " R9 ackreg"}, v, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 done", {31'b0, done}, 32'd0);
        chk("R1 abort", {31'b0, abrt}, 32'd0);
        rd(2'd0, v); chk("R1 reqreg", v, 32'd0);
        rd(2'd1, v); chk("R1 ackreg", v, 32'd0);
    endtask

    task automatic t_complete();
        logic [31:0] v;
        raise(4'h3, 4'hA, 8'h5C);
        rd(2'd0, v); chk("R2 layout", v, req_word(4'h3, 4'hA, 8'h5C, 1'b1));
        chk("R4 irq raised", {31'b0, irq}, 32'd1);
        step();
        chk("R4 irq held", {31'b0, irq}, 32'd1);
        wr(2'd1, 32'h1);
        chk("R5 done", {31'b0, done}, 32'd1);
        chk("R5 abort low", {31'b0, abrt}, 32'd0);
        chk("R4 irq cleared", {31'b0, irq}, 32'd0);
        rd(2'd1, v); chk("R5 ack readback", v, 32'h1);
        withdraw("complete");
    endtask

    task automatic t_abort();
        logic [31:0] v;
        raise(4'hF, 4'h1, 8'hFF);
        rd(2'd0, v); chk("R2 layout ones", v, req_word(4'hF, 4'h1, 8'hFF, 1'b1));
        wr(2'd1, 32'h2);
        chk("R5 abort", {31'b0, abrt}, 32'd1);
        chk("R5 done low", {31'b0, done}, 32'd0);
        rd(2'd1, v); chk("R5 abort readback", v, 32'h2);
        withdraw("abort");
    endtask

    task automatic t_both();
        logic [31:0] v;
        raise(4'h6, 4'h2, 8'h81);
        wr(2'd1, 32'h3);
        chk("R6 abort wins", {31'b0, abrt}, 32'd1);
        chk("R6 done not set", {31'b0, done}, 32'd0);
        rd(2'd1, v); chk("R6 ackreg", v, 32'h2);
        withdraw("both");
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        raise(4'h1, 4'h7, 8'h0F);
        wr(2'd1, 32'h1);
        wr(2'd1, 32'h2);
        chk("R7 abort ignored", {31'b0, abrt}, 32'd0);
        chk("R7 done kept", {31'b0, done}, 32'd1);
        rd(2'd1, v); chk("R7 ackreg", v, 32'h1);
        withdraw("sticky");
    endtask

    task automatic t_idle_write();
        logic [31:0] v;
        wr(2'd1, 32'h1);
        chk("R8 done idle", {31'b0, done}, 32'd0);
        rd(2'd1, v); chk("R8 ackreg idle", v, 32'd0);
        raise(4'h2, 4'h2, 8'h22);
        chk("R8 no stale result", {31'b0, done}, 32'd0);
        chk("R8 irq after raise", {31'b0, irq}, 32'd1);
        withdraw("idle");
    endtask

    task automatic t_capture();
        logic [31:0] v;
        raise(4'h9, 4'h4, 8'hA5);
        kind = 4'h0; dom = 4'hF; mask = 8'h3C;
        step();
        step();
        rd(2'd0, v); chk("R3 held fields", v, req_word(4'h9, 4'h4, 8'hA5, 1'b1));
        withdraw("capture");
        raise(4'h5, 4'h8, 8'h18);
        rd(2'd0, v); chk("R3 new capture", v, req_word(4'h5, 4'h8, 8'h18, 1'b1));
        withdraw("recapture");
    endtask

    task automatic t_other_addr();
        logic [31:0] v;
        raise(4'hC, 4'h3, 8'h77);
        wr(2'd2, 32'h3);
        wr(2'd3, 32'h3);
        chk("R10 no done", {31'b0, done}, 32'd0);
        chk("R10 no abort", {31'b0, abrt}, 32'd0);
        rd(2'd2, v); chk("R10 read 2", v, 32'd0);
        rd(2'd3, v); chk("R10 read 3", v, 32'd0);
        rd(2'd0, v); chk("R10 reqreg kept", v, req_word(4'hC, 4'h3, 8'h77, 1'b1));
        withdraw("other");
    endtask

    initial begin
        #150000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; kind = '0; dom = '0; mask = '0;
        wen = 1'b0; addr = '0; wdata = '0;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        t_reset();
        t_complete();
        t_abort();
        t_both();
        t_sticky();
        t_idle_write();
        t_capture();
        t_other_addr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule